// File: doc/BRIEF.md
# Dual-Mode Watchdog Timer Counter

This block is a two-stage down counter: an 8-bit prescaler advances on each tick-enable, and each time the prescaler wraps, an 8-bit counter steps down once. Writing a value to the counter starts a run. When the counter wraps past zero the run stops and a sticky underflow flag goes high. If the reset-enable bit is set, the same wrap also raises a watchdog reset request. Otherwise the block acts as a one-shot general-purpose timer.

Software can write the reset-enable bit only once. Only an external or brown-out reset unlocks it again. A run-enable bit that software cannot see decides whether the prescaler moves. Four events each change the state elements in their own way: external or brown-out reset, the block's own watchdog reset, HALT entry, and a counter load. The watchdog reset request is fed back inside the block, so the cycle in which it is high applies the watchdog-reset state changes.

Top module: `wdt_dual_timer`

## Requirements
- R1: An external or brown-out reset clears the underflow flag, the reset-enable bit and the request output, stops the timer so that no underflow follows however many ticks arrive, and unlocks the reset-enable bit for a new write.
- R2: Loading value n-1 starts the timer. The underflow flag reads 1 right after the clock edge that samples the 256·n-th tick-enable following the load edge, and reads 0 before that edge.
- R3: Cycles with tick-enable low do not advance the timer. Only cycles with tick-enable high are counted.
- R4: An underflow sets the flag and stops the timer. The flag stays 1 with no further underflow. When the reset-enable bit is 0, the request output stays low.
- R5: When the reset-enable bit is 1, the request output goes high at the same edge that sets the underflow flag and stays high for exactly one cycle.
- R6: The cycle in which the request is high acts as a watchdog reset. The flag and the reset-enable bit keep their values and the timer stops.
- R7: The first write to the reset-enable bit after an external or brown-out reset takes effect. Later writes are ignored until the next such reset.
- R8: A counter load clears the underflow flag and restarts the timer from the loaded value.
- R9: HALT entry clears the underflow flag and sets the prescaler and counter to all ones. It keeps the run state: a stopped timer stays stopped, and a running timer underflows 65536 ticks after the HALT edge.
- R10: If a counter load falls in the cycle where an underflow would occur, the load wins. The flag stays 0 and the new run takes the full count.
- R11: Event priority is external/brown-out reset, then watchdog reset, then HALT entry, then counter load, then counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| tick_en | input | 1 | Prescaler advance enable |
| load_we | input | 1 | Counter load strobe |
| load_data | input | CNT_W | Value written to the counter (n-1 for n counts) |
| ren_we | input | 1 | Reset-enable write strobe |
| ren_wdata | input | 1 | Reset-enable write value |
| halt_enter | input | 1 | HALT entry event |
| ext_rst | input | 1 | External reset event |
| bor_rst | input | 1 | Brown-out reset event |
| ufl_flag | output | 1 | Underflow flag (read-only) |
| ren_bit | output | 1 | Reset-enable bit read-back |
| wd_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench checks the exact edge at which the flag rises for two load values and for sparse ticks. A design that counts 255 instead of 256 per prescaler round, or that counts idle cycles, shows the flag one or many cycles early. It loads a new value in the very cycle of an underflow, where a design with the wrong priority would set the flag. It keeps ticking long after each underflow to catch a timer that reloads itself or a request that fires twice. It writes the reset-enable bit a second time, across a watchdog reset and across a brown-out reset, to catch a lock that never sets or that a watchdog reset clears. It enters HALT while running and checks that the restart takes the full 65536 ticks, which exposes a HALT that stops the timer or leaves the counter alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // State-changing events, highest priority first in wdt_evt_arb
   typedef enum logic [2:0] {
      EVT_NONE  = 3'd0,
      EVT_POWER = 3'd1,
      EVT_WDOG  = 3'd2,
      EVT_HALT  = 3'd3,
      EVT_LOAD  = 3'd4
   } wdt_evt_e;
endpackage

// File: rtl/wdt_evt_arb.sv
module wdt_evt_arb
   import wdt_pkg::*;
(
   input  logic     ext_rst,
   input  logic     bor_rst,
   input  logic     wd_req,
   input  logic     halt_enter,
   input  logic     load_we,
   output wdt_evt_e evt
);
   always_comb begin
      if (ext_rst || bor_rst) evt = EVT_POWER;
      else if (wd_req)        evt = EVT_WDOG;
      else if (halt_enter)    evt = EVT_HALT;
      else if (load_we)       evt = EVT_LOAD;
      else                    evt = EVT_NONE;
   end
endmodule

// File: rtl/wdt_down_stage.sv
module wdt_down_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         preset,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic         wrap
);
   localparam logic [W-1:0] ONES = {W{1'b1}};
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (preset)      q <= ONES;
      else if (load)   q <= load_val;
      else if (step)   q <= q - ONE;
   end

   assign wrap = step && (q == '0);
endmodule

// File: rtl/wdt_ctrl_bits.sv
module wdt_ctrl_bits
   import wdt_pkg::*;
(
   input  logic     clk,
   input  wdt_evt_e evt,
   input  logic     underflow,
   input  logic     ren_we,
   input  logic     ren_wdata,
   output logic     ren,
   output logic     ufl,
   output logic     run_en,
   output logic     req
);
   logic ren_lock;

   // reset-enable: one write per power/external reset
   always_ff @(posedge clk) begin
      if (evt == EVT_POWER) begin
         ren      <= 1'b0;
         ren_lock <= 1'b0;
      end else if (ren_we && !ren_lock) begin
         ren      <= ren_wdata;
         ren_lock <= 1'b1;
      end
   end

   // hidden run enable and visible flag
   always_ff @(posedge clk) begin
      unique case (evt)
         EVT_POWER: begin run_en <= 1'b0; ufl <= 1'b0; end
         EVT_WDOG:  begin run_en <= 1'b0; end
         EVT_HALT:  begin ufl <= 1'b0; end
         EVT_LOAD:  begin run_en <= 1'b1; ufl <= 1'b0; end
         default: begin
            if (underflow) begin
               run_en <= 1'b0;
               ufl    <= 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (evt == EVT_POWER) req <= 1'b0;
      else                  req <= underflow && ren;
   end
endmodule

// File: rtl/wdt_dual_timer.sv
module wdt_dual_timer
   import wdt_pkg::*;
#(
   parameter int PRE_W = 8,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             tick_en,
   input  logic             load_we,
   input  logic [CNT_W-1:0] load_data,
   input  logic             ren_we,
   input  logic             ren_wdata,
   input  logic             halt_enter,
   input  logic             ext_rst,
   input  logic             bor_rst,
   output logic             ufl_flag,
   output logic             ren_bit,
   output logic             wd_rst_req
);
   localparam logic [PRE_W-1:0] PRE_ONES = {PRE_W{1'b1}};

   generate
      if (PRE_W < 2) begin : g_bad_pre
         initial $error("wdt_dual_timer: PRE_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         initial $error("wdt_dual_timer: CNT_W must be at least 1");
      end
   endgenerate

   wdt_evt_e evt;
   logic     run_en;
   logic     pre_step, pre_wrap, cnt_wrap;
   logic     force_ones;

   wdt_evt_arb u_arb (
      .ext_rst    (ext_rst),
      .bor_rst    (bor_rst),
      .wd_req     (wd_rst_req),
      .halt_enter (halt_enter),
      .load_we    (load_we),
      .evt        (evt)
   );

   assign force_ones = (evt == EVT_POWER) || (evt == EVT_WDOG) || (evt == EVT_HALT);
   assign pre_step   = tick_en && run_en && (evt == EVT_NONE);

   wdt_down_stage #(.W(PRE_W)) u_pre (
      .clk      (clk),
      .preset   (force_ones || (evt == EVT_LOAD)),
      .load     (1'b0),
      .load_val (PRE_ONES),
      .step     (pre_step),
      .wrap     (pre_wrap)
   );

   wdt_down_stage #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .preset   (force_ones),
      .load     (evt == EVT_LOAD),
      .load_val (load_data),
      .step     (pre_wrap),
      .wrap     (cnt_wrap)
   );

   wdt_ctrl_bits u_ctrl (
      .clk       (clk),
      .evt       (evt),
      .underflow (cnt_wrap),
      .ren_we    (ren_we),
      .ren_wdata (ren_wdata),
      .ren       (ren_bit),
      .ufl       (ufl_flag),
      .run_en    (run_en),
      .req       (wd_rst_req)
   );
endmodule

// File: rtl/wdt_dual_timer_chk.sv
module wdt_dual_timer_chk (
   input logic clk,
   input logic ext_rst,
   input logic bor_rst,
   input logic halt_enter,
   input logic load_we,
   input logic ren_we,
   input logic ufl_flag,
   input logic ren_bit,
   input logic wd_rst_req
);
   logic armed = 1'b0;
   always_ff @(posedge clk) armed <= armed | ext_rst | bor_rst;

   // R1
   power_clear_chk: assert property (@(posedge clk) disable iff (!armed)
      (ext_rst || bor_rst) |=> (!ufl_flag && !ren_bit && !wd_rst_req));

   // R5
   req_single_chk: assert property (@(posedge clk) disable iff (!armed || ext_rst || bor_rst)
      wd_rst_req |=> !wd_rst_req);

   // R5
   req_needs_ren_chk: assert property (@(posedge clk) disable iff (!armed || ext_rst || bor_rst)
      wd_rst_req |-> (ren_bit && ufl_flag));

   // R6
   wdog_keeps_chk: assert property (@(posedge clk) disable iff (!armed || ext_rst || bor_rst)
      wd_rst_req |=> (ufl_flag && ren_bit));

   // R7
   ren_write_only_chk: assert property (@(posedge clk) disable iff (!armed || ext_rst || bor_rst)
      (!$past(ext_rst || bor_rst) && !$past(ren_we)) |-> $stable(ren_bit));

   // R8
   load_clears_chk: assert property (@(posedge clk) disable iff (!armed || ext_rst || bor_rst)
      (load_we && !halt_enter && !wd_rst_req) |=> !ufl_flag);

   // R9
   halt_clears_chk: assert property (@(posedge clk) disable iff (!armed || ext_rst || bor_rst)
      (halt_enter && !wd_rst_req) |=> !ufl_flag);
endmodule

bind wdt_dual_timer wdt_dual_timer_chk u_chk (
   .clk        (clk),
   .ext_rst    (ext_rst),
   .bor_rst    (bor_rst),
   .halt_enter (halt_enter),
   .load_we    (load_we),
   .ren_we     (ren_we),
   .ufl_flag   (ufl_flag),
   .ren_bit    (ren_bit),
   .wd_rst_req (wd_rst_req)
);

// File: tb/wdt_dual_timer_bench.sv
module wdt_dual_timer_bench;
   logic       clk = 1'b0;
   logic       tick_en = 1'b1;
   logic       load_we = 1'b0;
   logic [7:0] load_data = 8'h00;
   logic       ren_we = 1'b0;
   logic       ren_wdata = 1'b0;
   logic       halt_enter = 1'b0;
   logic       ext_rst = 1'b0;
   logic       bor_rst = 1'b0;
   logic       ufl_flag, ren_bit, wd_rst_req;

   int  nchk = 0;
   int  nerr = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   wdt_dual_timer u_wdt_dual_timer (
      .clk(clk), .tick_en(tick_en), .load_we(load_we), .load_data(load_data),
      .ren_we(ren_we), .ren_wdata(ren_wdata), .halt_enter(halt_enter),
      .ext_rst(ext_rst), .bor_rst(bor_rst),
      .ufl_flag(ufl_flag), .ren_bit(ren_bit), .wd_rst_req(wd_rst_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic pwr(input bit use_bor);
      ext_rst = !use_bor; bor_rst = use_bor;
      @(negedge clk);
      ext_rst = 1'b0; bor_rst = 1'b0;
   endtask

   task automatic ld(input logic [7:0] v);
      load_we = 1'b1; load_data = v;
      @(negedge clk);
      load_we = 1'b0;
   endtask

   task automatic wren(input logic v);
      ren_we = 1'b1; ren_wdata = v;
      @(negedge clk);
      ren_we = 1'b0;
   endtask

   task automatic halt_pulse();
      halt_enter = 1'b1;
      @(negedge clk);
      halt_enter = 1'b0;
   endtask

   task automatic count_req(input int k, output int hits);
      hits = 0;
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         if (wd_rst_req) hits++;
      end
   endtask

   task automatic t_reset();
      pwr(1'b0);
      chk("R1 flag after reset", ufl_flag, 0);
      chk("R1 ren after reset", ren_bit, 0);
      chk("R1 req after reset", wd_rst_req, 0);
      cyc(600);
      chk("R1 stopped timer no underflow", ufl_flag, 0);
   endtask

   task automatic t_count();
      pwr(1'b0);
      ld(8'd0);
      cyc(255);
      chk("R2 n=1 before last tick", ufl_flag, 0);
      cyc(1);
      chk("R2 n=1 at tick 256", ufl_flag, 1);
      ld(8'd2);
      chk("R8 load clears flag", ufl_flag, 0);
      cyc(767);
      chk("R2 n=3 before tick 768", ufl_flag, 0);
      cyc(1);
      chk("R2 n=3 at tick 768", ufl_flag, 1);
   endtask

   task automatic t_gaps();
      pwr(1'b0);
      ld(8'd0);
      for (int i = 0; i < 255; i++) begin
         tick_en = 1'b1; @(negedge clk);
         tick_en = 1'b0; @(negedge clk);
      end
      chk("R3 idle cycles not counted", ufl_flag, 0);
      tick_en = 1'b1; @(negedge clk);
      chk("R3 flag at 256th tick", ufl_flag, 1);
   endtask

   task automatic t_stop();
      int hits;
      pwr(1'b0);
      ld(8'd0);
      cyc(256);
      chk("R4 flag set", ufl_flag, 1);
      chk("R4 no request with ren=0", wd_rst_req, 0);
      count_req(700, hits);
      chk("R4 request never raised", hits, 0);
      chk("R4 flag sticky, timer stopped", ufl_flag, 1);
   endtask

   task automatic t_wdog();
      int hits;
      pwr(1'b0);
      wren(1'b1);
      chk("R7 first write takes", ren_bit, 1);
      ld(8'd0);
      cyc(255);
      chk("R5 no request early", wd_rst_req, 0);
      cyc(1);
      chk("R5 request with flag", wd_rst_req, 1);
      chk("R5 flag rises", ufl_flag, 1);
      cyc(1);
      chk("R5 request one cycle", wd_rst_req, 0);
      chk("R6 flag kept", ufl_flag, 1);
      chk("R6 ren kept", ren_bit, 1);
      count_req(700, hits);
      chk("R6 timer stopped after wdog", hits, 0);
      wren(1'b0);
      chk("R7 second write ignored", ren_bit, 1);
      ld(8'd0);
      chk("R8 load after wdog clears flag", ufl_flag, 0);
      cyc(256);
      chk("R8 restart after wdog", ufl_flag, 1);
      chk("R5 request again", wd_rst_req, 1);
      cyc(1);
      pwr(1'b1);
      chk("R1 brown-out clears ren", ren_bit, 0);
      chk("R1 brown-out clears flag", ufl_flag, 0);
      wren(1'b0);
      wren(1'b1);
      chk("R7 write of 0 locks", ren_bit, 0);
   endtask

   task automatic t_halt();
      pwr(1'b0);
      ld(8'd0);
      cyc(256);
      chk("R9 flag before halt", ufl_flag, 1);
      halt_pulse();
      chk("R9 halt clears flag", ufl_flag, 0);
      cyc(600);
      chk("R9 stopped stays stopped", ufl_flag, 0);
      ld(8'd0);
      cyc(100);
      halt_pulse();
      cyc(65535);
      chk("R9 running restart full count, early", ufl_flag, 0);
      cyc(1);
      chk("R9 underflow at 65536", ufl_flag, 1);
   endtask

   task automatic t_race();
      pwr(1'b0);
      ld(8'd0);
      cyc(255);
      ld(8'd0);
      chk("R10 load beats underflow", ufl_flag, 0);
      cyc(255);
      chk("R10 full count after race", ufl_flag, 0);
      cyc(1);
      chk("R10 underflow of new run", ufl_flag, 1);
   endtask

   task automatic t_prio();
      pwr(1'b0);
      ld(8'd0);
      cyc(10);
      halt_enter = 1'b1; load_we = 1'b1; load_data = 8'd0;
      @(negedge clk);
      halt_enter = 1'b0; load_we = 1'b0;
      cyc(256);
      chk("R11 halt beats load", ufl_flag, 0);
      ext_rst = 1'b1; ren_we = 1'b1; ren_wdata = 1'b1;
      @(negedge clk);
      ext_rst = 1'b0; ren_we = 1'b0;
      chk("R11 reset beats ren write", ren_bit, 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_count();
      t_gaps();
      t_stop();
      t_wdog();
      t_halt();
      t_race();
      t_prio();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL timeout R1 act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end
endmodule